// File: doc/BRIEF.md
# Debug Register Command Handler

This block executes commands for a serial background-debug port. The serial shifter sits outside it. Each time the shifter completes a 16-bit word, it strobes `word_valid` for one cycle. The block then loads `rsp_word` with the 17-bit word that the shifter sends back during the next exchange. Bit 16 is a status bit and bits 15:0 are data. Responses therefore lag their commands by exactly one word.

Two commands are supported: a read and a write of the debug configuration/status register (CSR). The CSR holds four event flags and a breakpoint-status field, which are set by strobes from the breakpoint and halt logic, and a 16-bit configuration field that the write command loads. A read clears the flags. It clears the breakpoint-status field only when the trigger level makes the breakpoint sequence complete.

The sequencer has six named states:

- IDLE decodes a command word.
  - A legal read goes to RD_LSW.
  - A write goes to WR_SEL_HI.
  - An illegal word stays in IDLE.
- RD_LSW ignores its incoming word and returns to IDLE.
- The write path steps through four states, one per operand word: WR_SEL_HI, then WR_SEL_LO, then WR_DAT_HI, then WR_DAT_LO. From WR_DAT_LO it returns to IDLE.

Top module: `dbg_reg_cmd`

## Requirements
- R1: After reset, `rsp_word` is 0x1_0000 (not ready) and the CSR reads as 0x0000_0000.
- R2: `rsp_word` changes only in the cycle after a `word_valid` pulse, and then it holds the response for the word just accepted.
- R3: The read command is 0x2D80 (bits 4:0 are the register select, and only select 0 is legal). Its response is CSR[31:16] with bit 16 clear. The next word is ignored, and its response is CSR[15:0] with bit 16 clear. The word after that is decoded as a new command.
- R4: A read with a select from 0x01 to 0x1F, or any word that is neither the read nor the write command, answers 0x1_0001. No register changes, and the next word is decoded as a command.
- R5: A read returns the CSR value as it was before the read. The read then clears the flags FOF (bit 27), TRG (bit 26), HALT (bit 25) and BKPT (bit 24). Inputs `flag_evt[3:0]` set these bits in that order, from bit 3 down to bit 0.
- R6: The breakpoint-status field CSR[31:28] holds 0x1 after a level-1 strobe and 0x2 after a level-2 strobe. A read clears it when it is 0x2. A read also clears it when it is 0x1 and the level-2 enable bit CSR[8] is 0. Otherwise the read leaves it unchanged.
- R7: An event strobe in the same cycle as a clearing read leaves its flag set.
- R8: The write command is 0x2C80. It takes four operand words in this order: select high, select low, data high, data low. The first four responses of a write are 0x1_0000. The final response is 0x0_FFFF, and the data low word is written into CSR[15:0].
- R9: If `wr_bus_err` is high when the final write word is accepted, the response is 0x1_0001 and the CSR is unchanged.
- R10: A write whose 32-bit select is not zero answers 0x1_0001 on its final word and leaves the CSR unchanged.
- R11: A level-2 strobe overrides level 1, and a later level-1 strobe does not lower a field that holds 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | One-cycle strobe: a command word has arrived |
| word_in | input | 16 | Received command or operand word |
| wr_bus_err | input | 1 | Write completion failed, sampled with the final write word |
| flag_evt | input | 4 | Event strobes for FOF, TRG, HALT, BKPT (bit 3 down to 0) |
| brk_l1 | input | 1 | Level-1 breakpoint triggered |
| brk_l2 | input | 1 | Level-2 breakpoint triggered |
| rsp_word | output | 17 | Response for the next exchange: {status, data} |

## Verification
The bench targets the one-word lag in three places:

- After a read command, it expects the low half on the ignored word.
- Straight after an illegal word, it sends a new command. A design that stays busy, or decodes the ignored word, shifts every later response by one.
- It strobes an event in the same cycle a read is accepted. Letting the clear win would lose that event, and capturing the value after the update would report it too early.

The breakpoint field is read with the level-2 enable both set and clear, so a design that ignores the enable condition shows a wrong high half. Write completions with a bus error and with a nonzero select must leave the CSR untouched, and a later read exposes any stray update.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    localparam int WORD_W = 16;
    localparam int RSP_W  = WORD_W + 1;
    localparam int REG_W  = 2 * WORD_W;
    localparam int SEL_W  = 5;
    localparam int FLAG_N = 4;

    // CSR layout
    localparam int FLAG_LSB  = 24;
    localparam int BST_LSB   = 28;
    localparam int BST_W     = 4;
    localparam int CFG_W     = 16;
    localparam int L2EN_BIT  = 8;

    // command words
    localparam logic [WORD_W-SEL_W-1:0] RD_OPC = 11'b0010_1101_100;
    localparam logic [WORD_W-1:0]       WR_CMD = 16'h2C80;

    // responses
    localparam logic [RSP_W-1:0] RSP_NOT_READY = 17'h1_0000;
    localparam logic [RSP_W-1:0] RSP_ERROR     = 17'h1_0001;
    localparam logic [RSP_W-1:0] RSP_WR_DONE   = 17'h0_FFFF;

    localparam logic [BST_W-1:0] BST_NONE = 4'h0;
    localparam logic [BST_W-1:0] BST_LVL1 = 4'h1;
    localparam logic [BST_W-1:0] BST_LVL2 = 4'h2;

    typedef enum logic [1:0] {
        K_READ,
        K_WRITE,
        K_ILLEGAL
    } cmd_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LSW,
        ST_WR_SEL_HI,
        ST_WR_SEL_LO,
        ST_WR_DAT_HI,
        ST_WR_DAT_LO
    } seq_state_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_cmd_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    output cmd_kind_t         kind
);
    logic [SEL_W-1:0] sel;
    logic             rd_match;

    assign sel      = cmd_word[SEL_W-1:0];
    assign rd_match = (cmd_word[WORD_W-1:SEL_W] == RD_OPC);

    always_comb begin
        if (rd_match && sel == '0)
            kind = K_READ;
        else if (cmd_word == WR_CMD)
            kind = K_WRITE;
        else
            kind = K_ILLEGAL;
    end
endmodule

// File: rtl/dbg_csr.sv
module dbg_csr
    import dbg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] flag_evt,
    input  logic              brk_l1,
    input  logic              brk_l2,
    input  logic              rd_clr,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_cfg,
    output logic [REG_W-1:0]  csr_q
);
    logic [FLAG_N-1:0] flag_q;
    logic [BST_W-1:0]  bst_q;
    logic [BST_W-1:0]  bst_base;
    logic [BST_W-1:0]  bst_d;
    logic [CFG_W-1:0]  cfg_q;
    logic              bst_clr;

    // event flags: a set strobe beats a clearing read
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (flag_evt[i])
                flag_q[i] <= 1'b1;
            else if (rd_clr)
                flag_q[i] <= 1'b0;
        end

        p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flag_evt[i] |=> csr_q[FLAG_LSB+i]);
        p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !flag_evt[i]) |=> !csr_q[FLAG_LSB+i]);
    end

    // breakpoint status
    always_comb begin
        bst_clr  = rd_clr && ((bst_q == BST_LVL2) ||
                              (bst_q == BST_LVL1 && !cfg_q[L2EN_BIT]));
        bst_base = bst_clr ? BST_NONE : bst_q;
        if (brk_l2)
            bst_d = BST_LVL2;
        else if (brk_l1 && bst_base != BST_LVL2)
            bst_d = BST_LVL1;
        else
            bst_d = bst_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bst_q <= BST_NONE;
        else
            bst_q <= bst_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= wr_cfg;
    end

    always_comb begin
        csr_q = '0;
        csr_q[BST_LSB +: BST_W]   = bst_q;
        csr_q[FLAG_LSB +: FLAG_N] = flag_q;
        csr_q[CFG_W-1:0]          = cfg_q;
    end

    p_bst_l2_r11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_l2 |=> csr_q[BST_LSB +: BST_W] == BST_LVL2);
    p_bst_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !brk_l1 && !brk_l2) |=> $stable(csr_q[BST_LSB +: BST_W]));
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(csr_q[CFG_W-1:0]));
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              wr_bus_err,
    input  cmd_kind_t         kind,
    input  logic [REG_W-1:0]  csr_q,
    output logic              rd_clr,
    output logic              wr_en,
    output logic [CFG_W-1:0]  wr_cfg,
    output logic [RSP_W-1:0]  rsp_word
);
    seq_state_t         state_q;
    seq_state_t         state_d;
    logic [RSP_W-1:0]   rsp_d;
    logic [WORD_W-1:0]  lsw_q;
    logic               sel_bad_q;
    logic               sel_bad_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state, controls and response
    always_comb begin
        state_d   = state_q;
        rsp_d     = rsp_word;
        sel_bad_d = sel_bad_q;
        rd_clr    = 1'b0;
        wr_en     = 1'b0;
        wr_cfg    = word_in[CFG_W-1:0];
        if (word_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    unique case (kind)
                        K_READ: begin
                            rd_clr  = 1'b1;
                            rsp_d   = {1'b0, csr_q[REG_W-1:WORD_W]};
                            state_d = ST_RD_LSW;
                        end
                        K_WRITE: begin
                            rsp_d   = RSP_NOT_READY;
                            state_d = ST_WR_SEL_HI;
                        end
                        default: begin
                            rsp_d   = RSP_ERROR;
                            state_d = ST_IDLE;
                        end
                    endcase
                end
                ST_RD_LSW: begin
                    rsp_d   = {1'b0, lsw_q};
                    state_d = ST_IDLE;
                end
                ST_WR_SEL_HI: begin
                    sel_bad_d = (word_in != '0);
                    rsp_d     = RSP_NOT_READY;
                    state_d   = ST_WR_SEL_LO;
                end
                ST_WR_SEL_LO: begin
                    sel_bad_d = sel_bad_q || (word_in != '0);
                    rsp_d     = RSP_NOT_READY;
                    state_d   = ST_WR_DAT_HI;
                end
                ST_WR_DAT_HI: begin
                    rsp_d   = RSP_NOT_READY;
                    state_d = ST_WR_DAT_LO;
                end
                ST_WR_DAT_LO: begin
                    if (sel_bad_q || wr_bus_err) begin
                        rsp_d = RSP_ERROR;
                    end else begin
                        rsp_d = RSP_WR_DONE;
                        wr_en = 1'b1;
                    end
                    state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // output and holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_word  <= RSP_NOT_READY;
            lsw_q     <= '0;
            sel_bad_q <= 1'b0;
        end else begin
            rsp_word  <= rsp_d;
            sel_bad_q <= sel_bad_d;
            if (rd_clr)
                lsw_q <= csr_q[WORD_W-1:0];
        end
    end

    p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(rsp_word));
    p_rd_one_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && state_q == ST_RD_LSW) |=> state_q == ST_IDLE);
    p_illegal_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && state_q == ST_IDLE && kind == K_ILLEGAL)
            |=> (rsp_word == RSP_ERROR && state_q == ST_IDLE));
    p_wr_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && (state_q == ST_WR_SEL_HI || state_q == ST_WR_SEL_LO ||
                        state_q == ST_WR_DAT_HI))
            |=> rsp_word == RSP_NOT_READY);
    p_err_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bus_err && state_q == ST_WR_DAT_LO) |-> !wr_en);
    p_sel_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bad_q && state_q == ST_WR_DAT_LO) |-> !wr_en);
endmodule

// File: rtl/dbg_reg_cmd.sv
module dbg_reg_cmd
    import dbg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              wr_bus_err,
    input  logic [FLAG_N-1:0] flag_evt,
    input  logic              brk_l1,
    input  logic              brk_l2,
    output logic [RSP_W-1:0]  rsp_word
);
    cmd_kind_t        kind;
    logic [REG_W-1:0] csr_q;
    logic             rd_clr;
    logic             wr_en;
    logic [CFG_W-1:0] wr_cfg;

    dbg_cmd_decode u_decode (
        .cmd_word (word_in),
        .kind     (kind)
    );

    dbg_cmd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_in    (word_in),
        .wr_bus_err (wr_bus_err),
        .kind       (kind),
        .csr_q      (csr_q),
        .rd_clr     (rd_clr),
        .wr_en      (wr_en),
        .wr_cfg     (wr_cfg),
        .rsp_word   (rsp_word)
    );

    dbg_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_evt (flag_evt),
        .brk_l1   (brk_l1),
        .brk_l2   (brk_l2),
        .rd_clr   (rd_clr),
        .wr_en    (wr_en),
        .wr_cfg   (wr_cfg),
        .csr_q    (csr_q)
    );

    p_rst_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> rsp_word == RSP_NOT_READY);
endmodule

// File: tb/test_dbg_reg_cmd.sv
`timescale 1ns/1ps
module test_dbg_reg_cmd;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_in = '0;
    logic        wr_bus_err = 1'b0;
    logic [3:0]  flag_evt = '0;
    logic        brk_l1 = 1'b0;
    logic        brk_l2 = 1'b0;
    logic [16:0] rsp_word;

    int checks = 0;
    int errors = 0;
    logic [16:0] exp_q[$];
    string       tag_q[$];
    logic        acc_d = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    dbg_reg_cmd i_dbg_reg_cmd (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .wr_bus_err(wr_bus_err), .flag_evt(flag_evt), .brk_l1(brk_l1),
        .brk_l2(brk_l2), .rsp_word(rsp_word)
    );

    task automatic check(input logic [16:0] act, input logic [16:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one word plus optional same-cycle strobes
    task automatic send_ev(input logic [15:0] w, input logic err, input logic [3:0] ev,
                           input logic l1, input logic l2,
                           input logic [16:0] exp, input string tag);
        @(negedge clk);
        word_in = w; wr_bus_err = err; word_valid = 1'b1;
        flag_evt = ev; brk_l1 = l1; brk_l2 = l2;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        word_valid = 1'b0; wr_bus_err = 1'b0; flag_evt = '0; brk_l1 = 1'b0; brk_l2 = 1'b0;
    endtask

    task automatic send(input logic [15:0] w, input logic [16:0] exp, input string tag);
        send_ev(w, 1'b0, 4'h0, 1'b0, 1'b0, exp, tag);
    endtask

    task automatic strobe(input logic [3:0] ev, input logic l1, input logic l2);
        @(negedge clk);
        flag_evt = ev; brk_l1 = l1; brk_l2 = l2;
        @(negedge clk);
        flag_evt = '0; brk_l1 = 1'b0; brk_l2 = 1'b0;
    endtask

    task automatic read_csr(input logic [31:0] v, input string tag);
        send(16'h2D80, {1'b0, v[31:16]}, tag);
        send(16'hBEEF, {1'b0, v[15:0]}, tag);
    endtask

    task automatic write_csr(input logic [15:0] sh, input logic [15:0] sl,
                             input logic [15:0] dl, input logic err,
                             input logic [16:0] fin, input string tag);
        send(16'h2C80, 17'h1_0000, tag);
        send(sh, 17'h1_0000, tag);
        send(sl, 17'h1_0000, tag);
        send(16'h1234, 17'h1_0000, tag);
        send_ev(dl, err, 4'h0, 1'b0, 1'b0, fin, tag);
    endtask

    // monitor / scoreboard
    always @(posedge clk) acc_d <= word_valid;
    always @(negedge clk) begin
        if (acc_d) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected response actual=%h expected=none", rsp_word);
            end else begin
                check(rsp_word, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [16:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_word, 17'h1_0000, "R1 reset response");
        read_csr(32'h0000_0000, "R1 reset csr / R3 read");

        // R2: idle cycles do not change the response
        hold = rsp_word;
        repeat (5) @(negedge clk);
        check(rsp_word, hold, "R2 hold without word");

        // R8 write
        write_csr(16'h0000, 16'h0000, 16'h0155, 1'b0, 17'h0_FFFF, "R8 write done");
        read_csr(32'h0000_0155, "R8 write visible");

        // R9 bus error
        write_csr(16'h0000, 16'h0000, 16'h00AA, 1'b1, 17'h1_0001, "R9 bus error");
        read_csr(32'h0000_0155, "R9 csr unchanged");

        // R10 bad select (low and high halves)
        write_csr(16'h0000, 16'h0001, 16'h00AA, 1'b0, 17'h1_0001, "R10 sel low");
        write_csr(16'h8000, 16'h0000, 16'h00AA, 1'b0, 17'h1_0001, "R10 sel high");
        read_csr(32'h0000_0155, "R10 csr unchanged");

        // R4 illegal words, each followed at once by a command
        send(16'h2D81, 17'h1_0001, "R4 reserved select");
        read_csr(32'h0000_0155, "R4 next word decoded");
        send(16'h1234, 17'h1_0001, "R4 unknown command");
        send(16'h2C81, 17'h1_0001, "R4 write with select bits");
        read_csr(32'h0000_0155, "R4 no change");

        // R5/R6: flags clear, level-1 kept while level-2 enabled (CSR[8]=1)
        strobe(4'hF, 1'b1, 1'b0);
        read_csr(32'h1F00_0155, "R5 flags set");
        read_csr(32'h1000_0155, "R5 flags cleared R6 lvl1 kept");
        strobe(4'h0, 1'b0, 1'b1);
        read_csr(32'h2000_0155, "R6 lvl2");
        read_csr(32'h0000_0155, "R6 lvl2 cleared");

        // R6 with level-2 enable clear
        write_csr(16'h0000, 16'h0000, 16'h0000, 1'b0, 17'h0_FFFF, "R8 write cfg 0");
        strobe(4'h0, 1'b1, 1'b0);
        read_csr(32'h1000_0000, "R6 lvl1 no l2en");
        read_csr(32'h0000_0000, "R6 lvl1 cleared");

        // R11 level-2 then level-1
        strobe(4'h0, 1'b0, 1'b1);
        strobe(4'h0, 1'b1, 1'b0);
        read_csr(32'h2000_0000, "R11 lvl2 kept");
        read_csr(32'h0000_0000, "R11 cleared");

        // R7 event in the same cycle as a clearing read
        send_ev(16'h2D80, 1'b0, 4'h2, 1'b0, 1'b0, 17'h0_0000, "R7 pre value");
        send(16'h0000, 17'h0_0000, "R7 pre value low");
        read_csr(32'h0200_0000, "R7 halt kept");
        read_csr(32'h0000_0000, "R7 then cleared");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule